// File: doc/BRIEF.md
# Dual-Channel IDE Expansion Card Glue

This block is the slave-side glue of an expansion card that carries two IDE channels. The host issues single-cycle byte accesses. Each access names one of two address regions: the fast I/O region or the extended region. The block decodes each access into one of the following:

- a select latch;
- a four-bit board identification strap;
- per-channel interrupt mask and status registers;
- taskfile and control chip selects with a register index for the IDE bus logic.

Each taskfile register sits on its own 64-byte stride inside a channel window.

The interrupt mask has a side-effect protocol. A write of any value to a channel's mask address enables that channel. A read of the same address disables it. The two drive interrupt lines, each qualified by its own enable, are merged into one card interrupt request. The extended region decodes only while the select latch holds its "open" bit. Clearing the latch therefore cuts off taskfile and interrupt-register access in one write.

Top module: `ide_card_glue`

## Requirements
- R1: After reset both channel interrupt enables are off, the select latch reads 0x00, and `card_irq`, `ext_open` and `dma_to_ch2` are 0.
- R2: With the extended region open, a write to offset 0x2200 (channel 0) or 0x3200 (channel 1) in the extended region enables that channel's interrupt, whatever the written data.
- R3: With the extended region open, a read of a channel's mask offset disables that channel's interrupt and returns 0x00.
- R4: Extended offsets 0x2290 (channel 0) and 0x3290 (channel 1) read back that channel's raw drive interrupt in bit 0, with bits 7..1 equal to 0.
- R5: `card_irq` is 1 exactly when some channel has its interrupt enabled and its drive interrupt high.
- R6: While `bus_sel` is high and the extended region is open, the following decoding applies. Offset 0x2000 + (n << 6), for n = 0..7, asserts `tf_cs[0]` with `tf_reg` = n. The same pattern at base 0x3000 asserts `tf_cs[1]`. Offsets 0x2380 and 0x3380 assert `ctl_cs[0]` and `ctl_cs[1]`. At most one select is high at a time, and none is high when `bus_sel` is low.
- R7: A write to offset 0x0000 of the fast region stores the byte in the select latch, which reads back at the same offset. Bit 5 drives `ext_open` and bit 0 drives `dma_to_ch2`.
- R8: Reads of fast offsets 0x2280, 0x2284, 0x2288 and 0x228C return `id_strap[0]`..`id_strap[3]` in bit 0, with bits 7..1 equal to 0.
- R9: While the select latch bit 5 is 0, extended-region accesses have no effect. They assert no chip select, return 0x00, and change no interrupt enable.
- R10: Accesses that decode to no register return 0x00 on reads and change no state on writes. This includes taskfile offsets with any of the low six address bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_region | input | 1 | 0 = fast I/O region, 1 = extended region |
| bus_addr | input | 16 | Byte offset within the region |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_sel` is high |
| drv_irq | input | 2 | Drive interrupt lines, one per channel |
| id_strap | input | 4 | Board identification strap |
| card_irq | output | 1 | Merged card interrupt request |
| ext_open | output | 1 | Extended region decode enabled (latch bit 5) |
| dma_to_ch2 | output | 1 | DMA request/acknowledge routed to channel 1 (latch bit 0) |
| tf_cs | output | 2 | Taskfile chip select per channel |
| ctl_cs | output | 2 | Control/alt-status chip select per channel |
| tf_reg | output | 3 | Taskfile register index |

## Verification
The hardest state to reach from the ports is a mixed enable pattern, with one channel armed and the other disarmed. The only evidence of it is `card_irq`, because the enables cannot be read without being destroyed. The bench therefore reaches each of the four enable patterns by disarming both channels with mask reads and re-arming a subset with writes of varying data. For every pattern it then sweeps all four drive-interrupt combinations and checks `card_irq`. Closed-region behaviour is reached by clearing latch bit 5 first and then repeating mask writes that would otherwise arm a channel.

// File: rtl/ide_glue_pkg.sv
package ide_glue_pkg;
   typedef enum logic [2:0] {
      K_NONE  = 3'd0,
      K_LATCH = 3'd1,
      K_IDENT = 3'd2,
      K_MASK  = 3'd3,
      K_STAT  = 3'd4,
      K_TF    = 3'd5,
      K_CTL   = 3'd6
   } hit_kind_e;

   localparam int TF_BASE_OFF = 32'h2000;
   localparam int CH_SPAN_OFF = 32'h1000;
   localparam int MASK_OFF    = 32'h0200;
   localparam int STAT_OFF    = 32'h0290;
   localparam int CTL_OFF     = 32'h0380;
   localparam int IDENT_OFF   = 32'h2280;
   localparam int IDENT_STEP  = 4;
endpackage

// File: rtl/ide_glue_decode.sv
module ide_glue_decode
   import ide_glue_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int CH_N      = 2,
   parameter int TF_REGS   = 8,
   parameter int STRIDE_SH = 6,
   parameter int ID_BITS   = 4,
   parameter int CH_W      = 1,
   parameter int SUB_W     = 3
) (
   input  logic              region,
   input  logic              ext_open,
   input  logic [ADDR_W-1:0] addr,
   output hit_kind_e         kind,
   output logic [CH_W-1:0]   ch_idx,
   output logic [SUB_W-1:0]  sub_idx
);
   always_comb begin
      kind    = K_NONE;
      ch_idx  = '0;
      sub_idx = '0;
      if (!region) begin
         if (addr == '0) kind = K_LATCH;
         for (int k = 0; k < ID_BITS; k++) begin
            if (addr == ADDR_W'(IDENT_OFF + k * IDENT_STEP)) begin
               kind    = K_IDENT;
               sub_idx = SUB_W'(k);
            end
         end
      end else if (ext_open) begin
         for (int c = 0; c < CH_N; c++) begin
            for (int i = 0; i < TF_REGS; i++) begin
               if (addr == ADDR_W'(TF_BASE_OFF + c * CH_SPAN_OFF + (i << STRIDE_SH))) begin
                  kind    = K_TF;
                  ch_idx  = CH_W'(c);
                  sub_idx = SUB_W'(i);
               end
            end
            if (addr == ADDR_W'(TF_BASE_OFF + c * CH_SPAN_OFF + CTL_OFF)) begin
               kind   = K_CTL;
               ch_idx = CH_W'(c);
            end
            if (addr == ADDR_W'(TF_BASE_OFF + c * CH_SPAN_OFF + MASK_OFF)) begin
               kind   = K_MASK;
               ch_idx = CH_W'(c);
            end
            if (addr == ADDR_W'(TF_BASE_OFF + c * CH_SPAN_OFF + STAT_OFF)) begin
               kind   = K_STAT;
               ch_idx = CH_W'(c);
            end
         end
      end
   end
endmodule

// File: rtl/ide_glue_latch.sv
module ide_glue_latch #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)  q <= '0;
      else if (wr) q <= wdata;
   end
endmodule

// File: rtl/ide_glue_irq.sv
module ide_glue_irq #(
   parameter int CH_N = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [CH_N-1:0] arm,
   input  logic [CH_N-1:0] disarm,
   input  logic [CH_N-1:0] drv_irq,
   output logic [CH_N-1:0] en,
   output logic            irq_out
);
   for (genvar c = 0; c < CH_N; c++) begin : g_ch
      always_ff @(posedge clk) begin
         if (!rst_n)         en[c] <= 1'b0;
         else if (arm[c])    en[c] <= 1'b1;
         else if (disarm[c]) en[c] <= 1'b0;
      end
   end
   assign irq_out = |(en & drv_irq);
endmodule

// File: rtl/ide_card_glue.sv
module ide_card_glue
   import ide_glue_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter int CH_N      = 2,
   parameter int TF_REGS   = 8,
   parameter int STRIDE_SH = 6,
   parameter int ID_BITS   = 4,
   parameter int OPEN_BIT  = 5,
   parameter int ROUTE_BIT = 0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         bus_sel,
   input  logic                         bus_we,
   input  logic                         bus_region,
   input  logic [ADDR_W-1:0]            bus_addr,
   input  logic [DATA_W-1:0]            bus_wdata,
   output logic [DATA_W-1:0]            bus_rdata,
   input  logic [CH_N-1:0]              drv_irq,
   input  logic [ID_BITS-1:0]           id_strap,
   output logic                         card_irq,
   output logic                         ext_open,
   output logic                         dma_to_ch2,
   output logic [CH_N-1:0]              tf_cs,
   output logic [CH_N-1:0]              ctl_cs,
   output logic [$clog2(TF_REGS)-1:0]   tf_reg
);
   localparam int CH_W  = (CH_N > 1) ? $clog2(CH_N) : 1;
   localparam int TR_W  = $clog2(TF_REGS);
   localparam int ID_W  = (ID_BITS > 1) ? $clog2(ID_BITS) : 1;
   localparam int SUB_W = (TR_W > ID_W) ? TR_W : ID_W;

   if (ADDR_W < 14 || ADDR_W > 31) begin : g_bad_addr
      $error("ide_card_glue: ADDR_W must be 14..31");
   end
   if (OPEN_BIT >= DATA_W || ROUTE_BIT >= DATA_W || OPEN_BIT == ROUTE_BIT) begin : g_bad_bits
      $error("ide_card_glue: latch bit positions invalid");
   end
   if (CH_N < 1 || TF_BASE_OFF + CH_N * CH_SPAN_OFF > (1 << ADDR_W)) begin : g_bad_ch
      $error("ide_card_glue: channel windows exceed address space");
   end
   if ((TF_REGS << STRIDE_SH) > MASK_OFF) begin : g_bad_stride
      $error("ide_card_glue: taskfile stride overlaps register block");
   end

   hit_kind_e         kind;
   logic [CH_W-1:0]   ch_idx;
   logic [SUB_W-1:0]  sub_idx;
   logic [DATA_W-1:0] latch_q;
   logic [CH_N-1:0]   irq_en;
   logic [CH_N-1:0]   arm;
   logic [CH_N-1:0]   disarm;

   ide_glue_decode #(
      .ADDR_W(ADDR_W), .CH_N(CH_N), .TF_REGS(TF_REGS), .STRIDE_SH(STRIDE_SH),
      .ID_BITS(ID_BITS), .CH_W(CH_W), .SUB_W(SUB_W)
   ) u_dec (
      .region(bus_region), .ext_open(ext_open), .addr(bus_addr),
      .kind(kind), .ch_idx(ch_idx), .sub_idx(sub_idx)
   );

   ide_glue_latch #(.DATA_W(DATA_W)) u_latch (
      .clk(clk), .rst_n(rst_n),
      .wr(bus_sel && bus_we && kind == K_LATCH),
      .wdata(bus_wdata), .q(latch_q)
   );

   assign ext_open   = latch_q[OPEN_BIT];
   assign dma_to_ch2 = latch_q[ROUTE_BIT];

   for (genvar c = 0; c < CH_N; c++) begin : g_sel
      logic ch_hit;
      assign ch_hit    = bus_sel && (ch_idx == CH_W'(c));
      assign arm[c]    = ch_hit && bus_we  && kind == K_MASK;
      assign disarm[c] = ch_hit && !bus_we && kind == K_MASK;
      assign tf_cs[c]  = ch_hit && kind == K_TF;
      assign ctl_cs[c] = ch_hit && kind == K_CTL;
   end

   assign tf_reg = (bus_sel && kind == K_TF) ? sub_idx[TR_W-1:0] : '0;

   ide_glue_irq #(.CH_N(CH_N)) u_irq (
      .clk(clk), .rst_n(rst_n), .arm(arm), .disarm(disarm),
      .drv_irq(drv_irq), .en(irq_en), .irq_out(card_irq)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_we) begin
         unique case (kind)
            K_LATCH: bus_rdata = latch_q;
            K_IDENT: bus_rdata = DATA_W'(id_strap[sub_idx[ID_W-1:0]]);
            K_STAT:  bus_rdata = DATA_W'(drv_irq[ch_idx]);
            default: bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/ide_card_glue_chk.sv
module ide_card_glue_chk #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int CH_N   = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_we,
   input logic              bus_region,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              ext_open,
   input logic [CH_N-1:0]   irq_en,
   input logic              card_irq,
   input logic [CH_N-1:0]   tf_cs,
   input logic [CH_N-1:0]   ctl_cs,
   input logic [DATA_W-1:0] latch_q
);
   logic mask0_hit;
   assign mask0_hit = bus_sel && bus_region && ext_open && bus_addr == ADDR_W'(32'h2200);

   a_r2_mask_write_arms: assert property (@(posedge clk) disable iff (!rst_n)
      (mask0_hit && bus_we) |=> irq_en[0]);

   a_r3_mask_read_disarms: assert property (@(posedge clk) disable iff (!rst_n)
      (mask0_hit && !bus_we) |=> !irq_en[0]);

   a_r5_quiet_when_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en == '0) |-> !card_irq);

   a_r6_single_select: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tf_cs, ctl_cs}));

   a_r6_idle_no_select: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_sel |-> ({tf_cs, ctl_cs} == '0));

   a_r9_closed_no_select: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_open |-> ({tf_cs, ctl_cs} == '0));

   a_r9_closed_enables_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_region && !ext_open) |=> $stable(irq_en));

   a_r10_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_we && !bus_region && bus_addr != '0) |=> $stable(latch_q));
endmodule

bind ide_card_glue ide_card_glue_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CH_N(CH_N)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
   .bus_region(bus_region), .bus_addr(bus_addr), .ext_open(ext_open),
   .irq_en(irq_en), .card_irq(card_irq), .tf_cs(tf_cs), .ctl_cs(ctl_cs),
   .latch_q(latch_q)
);

// File: tb/tb_ide_card_glue.sv
module tb_ide_card_glue;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_we = 1'b0;
   logic        bus_region = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [1:0]  drv_irq = '0;
   logic [3:0]  id_strap = '0;
   logic        card_irq, ext_open, dma_to_ch2;
   logic [1:0]  tf_cs, ctl_cs;
   logic [2:0]  tf_reg;

   int n_checks = 0;
   int n_errors = 0;
   logic [7:0] cap_rd;
   logic [1:0] cap_tf, cap_ctl;
   logic [2:0] cap_reg;

   always #10 clk = ~clk;

   ide_card_glue dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_region(bus_region), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .drv_irq(drv_irq), .id_strap(id_strap),
      .card_irq(card_irq), .ext_open(ext_open), .dma_to_ch2(dma_to_ch2),
      .tf_cs(tf_cs), .ctl_cs(ctl_cs), .tf_reg(tf_reg)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic op(input logic rg, input logic we, input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = we; bus_region = rg; bus_addr = a; bus_wdata = d;
      #2;
      cap_rd = bus_rdata; cap_tf = tf_cs; cap_ctl = ctl_cs; cap_reg = tf_reg;
      @(posedge clk);
      #1;
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic settle();
      @(negedge clk);
      #2;
   endtask

   initial begin
      #1_000_000;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      drv_irq = 2'b11;
      settle();
      chk("R1 card_irq", card_irq, 0);
      chk("R1 ext_open", ext_open, 0);
      chk("R1 dma_to_ch2", dma_to_ch2, 0);
      op(0, 0, 16'h0000, 0);
      chk("R1 latch readback", cap_rd, 0);

      // R9: region closed, mask writes and taskfile ignored
      op(1, 1, 16'h2200, 8'hFF);
      op(1, 1, 16'h3200, 8'hFF);
      settle();
      chk("R9 closed mask write no irq", card_irq, 0);
      op(1, 0, 16'h2290, 0);
      chk("R9 closed status read", cap_rd, 0);
      op(1, 0, 16'h2000, 0);
      chk("R9 closed no tf_cs", cap_tf, 0);
      op(1, 0, 16'h3380, 0);
      chk("R9 closed no ctl_cs", cap_ctl, 0);

      // R7: select latch
      op(0, 1, 16'h0000, 8'hA5);
      settle();
      chk("R7 ext_open", ext_open, 1);
      chk("R7 dma_to_ch2", dma_to_ch2, 1);
      op(0, 0, 16'h0000, 0);
      chk("R7 readback", cap_rd, 8'hA5);
      op(0, 1, 16'h0000, 8'h20);
      settle();
      chk("R7 route cleared", dma_to_ch2, 0);
      chk("R7 still open", ext_open, 1);

      // R8: identification strap sweep
      for (int s = 0; s < 16; s++) begin
         id_strap = 4'(s);
         for (int k = 0; k < 4; k++) begin
            op(0, 0, 16'(32'h2280 + 4 * k), 0);
            chk("R8 ident bit", cap_rd, (s >> k) & 1);
         end
      end

      // R4: status bits
      for (int p = 0; p < 4; p++) begin
         drv_irq = 2'(p);
         op(1, 0, 16'h2290, 8'h00);
         chk("R4 status ch0", cap_rd, p & 1);
         op(1, 0, 16'h3290, 8'h00);
         chk("R4 status ch1", cap_rd, (p >> 1) & 1);
      end

      // R2 R3 R5: enable patterns x drive patterns
      for (int e = 0; e < 4; e++) begin
         op(1, 0, 16'h2200, 0);
         chk("R3 mask read data", cap_rd, 0);
         op(1, 0, 16'h3200, 0);
         chk("R3 mask read data", cap_rd, 0);
         drv_irq = 2'b11;
         settle();
         chk("R3 disarmed card_irq", card_irq, 0);
         if (e[0]) op(1, 1, 16'h2200, 8'(e * 8'h55));
         if (e[1]) op(1, 1, 16'h3200, 8'(~(e * 8'h55)));
         for (int d = 0; d < 4; d++) begin
            drv_irq = 2'(d);
            settle();
            chk("R2 R5 merged irq", card_irq, ((e & d) != 0) ? 1 : 0);
         end
      end

      // R6: taskfile and control decode sweep
      for (int c = 0; c < 2; c++) begin
         for (int i = 0; i < 8; i++) begin
            op(1, 0, 16'(32'h2000 + c * 32'h1000 + (i << 6)), 0);
            chk("R6 tf_cs", cap_tf, 1 << c);
            chk("R6 tf_reg", cap_reg, i);
            chk("R6 no ctl_cs", cap_ctl, 0);
            op(1, 1, 16'(32'h2000 + c * 32'h1000 + (i << 6) + 1), 8'h00);
            chk("R10 misaligned no select", {cap_tf, cap_ctl}, 0);
         end
         op(1, 1, 16'(32'h2380 + c * 32'h1000), 8'h00);
         chk("R6 ctl_cs", cap_ctl, 1 << c);
         chk("R6 ctl no tf_cs", cap_tf, 0);
      end
      @(negedge clk);
      bus_region = 1'b1; bus_addr = 16'h2040;
      #2;
      chk("R6 idle no select", {tf_cs, ctl_cs}, 0);

      // R10: unmapped accesses
      op(0, 1, 16'h0001, 8'hFF);
      op(0, 1, 16'h2281, 8'hFF);
      op(0, 0, 16'h0000, 0);
      chk("R10 latch unchanged", cap_rd, 8'h20);
      op(0, 0, 16'h1234, 0);
      chk("R10 unmapped read", cap_rd, 0);
      op(1, 0, 16'h2210, 0);
      chk("R10 unmapped ext read", cap_rd, 0);
      op(1, 0, 16'h2200, 0);
      op(1, 1, 16'h2290, 8'hFF);
      drv_irq = 2'b01;
      settle();
      chk("R10 status write no arm", card_irq, 0);

      // R9: close the region, then try to arm
      op(0, 1, 16'h0000, 8'h00);
      settle();
      chk("R9 ext closed", ext_open, 0);
      op(1, 1, 16'h2200, 8'h01);
      settle();
      chk("R9 closed arm ignored", card_irq, 0);
      op(1, 0, 16'h2000, 0);
      chk("R9 closed tf ignored", cap_tf, 0);

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule